// File: doc/BRIEF.md
# UART Channel Command Register Decoder

This block sits behind one channel's command register in a dual UART. Each byte written to the register carries two things. The low five bits hold one encoded command. The upper three bits carry the transmitter and receiver enables, together with a lock bit that decides whether those enables are applied. Software can therefore issue a command without first finding out whether the channel is enabled: it leaves the lock bit clear and the stored enable states stay as they are.

Some commands are momentary: receiver and transmitter reset, error and break-change clear, break start and stop, mode-pointer reset, Xon/Xoff requests, transmitter resume, and counter/timer start and stop. Each of these appears as a one-clock pulse in the cycle after the write strobe is sampled, and the transmitter, receiver and counter/timer datapaths elsewhere act on it. The remaining commands set or clear a held level, each kept in its own two-state machine:

- RTS: states `RTS_NEGATED` and `RTS_ASSERTED`. The `rts_on` transition goes to `RTS_ASSERTED` and the `rts_off` transition goes back to `RTS_NEGATED`.
- Receiver timeout: states `TMO_OFF` and `TMO_ON`, with the `tmo_on` and `tmo_off` transitions.
- Error accumulation: states `ACC_AT_READ` and `ACC_AT_ENTRY`. Only the `acc_on` transition exists; hardware reset is the only way back.
- Power mode: states `PWR_RUN` and `PWR_DOWN`, with the `pwr_enter` and `pwr_leave` transitions.

Hardware reset puts every one of these machines in its first-named state. An enable update and the command from the same write take effect on the same clock edge.

Top module: `uart_cmd_decoder`

## Requirements
- R1: On a write with bit 7 equal to 0, bits 6 and 5 are ignored, and `tx_en` and `rx_en` keep their previous values.
- R2: On a write with bit 7 equal to 1, `tx_en` takes bit 6 and `rx_en` takes bit 5 in the cycle after the strobe. This is the same cycle in which that write's command pulse or level change appears.
- R3: Each momentary command code in bits 4:0 raises only its own pulse output, for exactly one cycle, in the cycle after the strobe. The codes are:
  - 00010 `rx_reset`
  - 00011 `tx_reset`
  - 00100 `err_clear`
  - 00101 `brk_chg_clear`
  - 00110 `brk_start`
  - 00111 `brk_stop`
  - 01011 `mrptr_reset`
  - 10000 `xon_req`
  - 10001 `xoff_req`
  - 10010 `ct_start`
  - 10011 `ct_stop`
  - 10110 `tx_resume`
- R4: Codes 00000, 00001, 10100, 10101 and 10111 through 11111 raise no pulse and change no level output.
- R5: At most one pulse output is high in any cycle, and a pulse falls in the cycle after it rose unless another write follows.
- R6: Code 01000 drives `rts_n` low and code 01001 drives it high. The level holds until the next such code.
- R7: Code 01010 sets `tmo_mode` to 1 and code 01100 sets it to 0.
- R8: Code 01101 sets `accum_mode` to 1, and it stays at 1 until hardware reset.
- R9: Code 01110 sets `pwr_down` to 1 and code 01111 sets it to 0.
- R10: While reset is applied (`rst_n` = 0), every pulse output is 0, the enables are 0, `tmo_mode`, `accum_mode` and `pwr_down` are 0, and `rts_n` is 1.
- R11: In a cycle with no write strobe, no pulse is raised and no level output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | 8 | Written byte: lock, transmitter enable, receiver enable, command code |
| tx_en | output | 1 | Stored transmitter enable |
| rx_en | output | 1 | Stored receiver enable |
| rx_reset | output | 1 | Pulse: reset receiver and its FIFO pointers |
| tx_reset | output | 1 | Pulse: reset transmitter and its FIFO pointers |
| err_clear | output | 1 | Pulse: clear break, parity, framing and overrun error bits |
| brk_chg_clear | output | 1 | Pulse: clear the break-change interrupt status |
| brk_start | output | 1 | Pulse: request start of break |
| brk_stop | output | 1 | Pulse: request end of break |
| mrptr_reset | output | 1 | Pulse: return the mode-register pointer to 0 |
| xon_req | output | 1 | Pulse: request transmission of an Xon character |
| xoff_req | output | 1 | Pulse: request transmission of an Xoff character |
| tx_resume | output | 1 | Pulse: cancel an earlier host Xoff |
| ct_start | output | 1 | Pulse: load the counter/timer from its preset and start it |
| ct_stop | output | 1 | Pulse: stop the counter/timer, capture the count, clear the ready status |
| rts_n | output | 1 | Active-low RTS level |
| tmo_mode | output | 1 | Counter/timer receiver timeout mode |
| accum_mode | output | 1 | Error accumulation at FIFO entry |
| pwr_down | output | 1 | Power-down mode |

## Verification
The enable update and the command from one write can land on the same clock edge. The bench provokes this by writing all 256 byte values once in ascending order and once in descending order, so that every command code is issued both with the lock set and with it clear, and from different starting enable states. After each write, the cycle after the strobe is judged as a whole: the enables, every pulse output and every level output are compared against values the bench computes from the byte. One cycle later the bench checks again to confirm that the pulse has fallen and that all levels have held.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;

    localparam int CMD_W      = 5;
    localparam int NUM_PULSES = 12;

    typedef enum logic [CMD_W-1:0] {
        C_NOP        = 5'h00,
        C_RSV_A      = 5'h01,
        C_RX_RST     = 5'h02,
        C_TX_RST     = 5'h03,
        C_ERR_CLR    = 5'h04,
        C_BRKCHG_CLR = 5'h05,
        C_BRK_START  = 5'h06,
        C_BRK_STOP   = 5'h07,
        C_RTS_ON     = 5'h08,
        C_RTS_OFF    = 5'h09,
        C_TMO_ON     = 5'h0A,
        C_MRP_RST    = 5'h0B,
        C_TMO_OFF    = 5'h0C,
        C_ACC_ON     = 5'h0D,
        C_PWR_ON     = 5'h0E,
        C_PWR_OFF    = 5'h0F,
        C_XON        = 5'h10,
        C_XOFF       = 5'h11,
        C_CT_START   = 5'h12,
        C_CT_STOP    = 5'h13,
        C_RSV_B      = 5'h14,
        C_RSV_C      = 5'h15,
        C_TX_RESUME  = 5'h16
    } cmd_code_e;

    // Positions in the pulse vector
    localparam int P_RX_RST     = 0;
    localparam int P_TX_RST     = 1;
    localparam int P_ERR_CLR    = 2;
    localparam int P_BRKCHG_CLR = 3;
    localparam int P_BRK_START  = 4;
    localparam int P_BRK_STOP   = 5;
    localparam int P_MRP_RST    = 6;
    localparam int P_XON        = 7;
    localparam int P_XOFF       = 8;
    localparam int P_TX_RESUME  = 9;
    localparam int P_CT_START   = 10;
    localparam int P_CT_STOP    = 11;

    typedef enum logic { RTS_NEGATED, RTS_ASSERTED } rts_state_e;
    typedef enum logic { TMO_OFF, TMO_ON } tmo_state_e;
    typedef enum logic { ACC_AT_READ, ACC_AT_ENTRY } acc_state_e;
    typedef enum logic { PWR_RUN, PWR_DOWN } pwr_state_e;

    // Command code that fires each pulse position
    function automatic logic [CMD_W-1:0] pulse_code(input int idx);
        logic [CMD_W-1:0] c;
        case (idx)
            P_RX_RST:     c = C_RX_RST;
            P_TX_RST:     c = C_TX_RST;
            P_ERR_CLR:    c = C_ERR_CLR;
            P_BRKCHG_CLR: c = C_BRKCHG_CLR;
            P_BRK_START:  c = C_BRK_START;
            P_BRK_STOP:   c = C_BRK_STOP;
            P_MRP_RST:    c = C_MRP_RST;
            P_XON:        c = C_XON;
            P_XOFF:       c = C_XOFF;
            P_TX_RESUME:  c = C_TX_RESUME;
            P_CT_START:   c = C_CT_START;
            default:      c = C_CT_STOP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cmd_enable_ctl.sv
module cmd_enable_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic lock_bit,
    input  logic tx_bit,
    input  logic rx_bit,
    output logic tx_en,
    output logic rx_en
);

    logic load;
    assign load = wr_en && lock_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en <= 1'b0;
            rx_en <= 1'b0;
        end else if (load) begin
            tx_en <= tx_bit;
            rx_en <= rx_bit;
        end
    end

    p_lock_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !lock_bit) |=> ($stable(tx_en) && $stable(rx_en)));

    p_lock_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock_bit) |=> (tx_en == $past(tx_bit) && rx_en == $past(rx_bit)));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(tx_en) && $stable(rx_en)));

endmodule

// File: rtl/cmd_pulse_gen.sv
module cmd_pulse_gen
    import uart_cmd_pkg::*;
#(
    parameter int N_PULSE = NUM_PULSES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CMD_W-1:0]   code,
    output logic [N_PULSE-1:0] pulse
);

    logic [N_PULSE-1:0] hit;

    for (genvar i = 0; i < N_PULSE; i++) begin : g_pulse
        assign hit[i] = wr_en && (code == pulse_code(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pulse[i] <= 1'b0;
            end else begin
                pulse[i] <= hit[i];
            end
        end
    end

    logic reserved_code;
    assign reserved_code = (code == C_NOP) || (code == C_RSV_A) ||
                           (code == C_RSV_B) || (code == C_RSV_C) ||
                           (code > C_TX_RESUME);

    p_reserved_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reserved_code) |=> (pulse == '0));

    p_pulse_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse));

    p_no_write_no_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (pulse == '0));

    p_ct_start_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && code == C_CT_START) |=> pulse[P_CT_START]);

endmodule

// File: rtl/cmd_mode_ctl.sv
module cmd_mode_ctl
    import uart_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] code,
    output logic             rts_n,
    output logic             tmo_mode,
    output logic             accum_mode,
    output logic             pwr_down
);

    rts_state_e rts_q, rts_d;
    tmo_state_e tmo_q, tmo_d;
    acc_state_e acc_q, acc_d;
    pwr_state_e pwr_q, pwr_d;

    logic rts_on, rts_off, tmo_on, tmo_off, acc_on, pwr_enter, pwr_leave;

    assign rts_on    = wr_en && (code == C_RTS_ON);
    assign rts_off   = wr_en && (code == C_RTS_OFF);
    assign tmo_on    = wr_en && (code == C_TMO_ON);
    assign tmo_off   = wr_en && (code == C_TMO_OFF);
    assign acc_on    = wr_en && (code == C_ACC_ON);
    assign pwr_enter = wr_en && (code == C_PWR_ON);
    assign pwr_leave = wr_en && (code == C_PWR_OFF);

    // Next-state logic
    always_comb begin
        rts_d = rts_q;
        unique case (rts_q)
            RTS_NEGATED:  if (rts_on)  rts_d = RTS_ASSERTED;
            RTS_ASSERTED: if (rts_off) rts_d = RTS_NEGATED;
        endcase

        tmo_d = tmo_q;
        unique case (tmo_q)
            TMO_OFF: if (tmo_on)  tmo_d = TMO_ON;
            TMO_ON:  if (tmo_off) tmo_d = TMO_OFF;
        endcase

        acc_d = acc_q;
        unique case (acc_q)
            ACC_AT_READ:  if (acc_on) acc_d = ACC_AT_ENTRY;
            ACC_AT_ENTRY: acc_d = ACC_AT_ENTRY;
        endcase

        pwr_d = pwr_q;
        unique case (pwr_q)
            PWR_RUN:  if (pwr_enter) pwr_d = PWR_DOWN;
            PWR_DOWN: if (pwr_leave) pwr_d = PWR_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rts_q <= RTS_NEGATED;
            tmo_q <= TMO_OFF;
            acc_q <= ACC_AT_READ;
            pwr_q <= PWR_RUN;
        end else begin
            rts_q <= rts_d;
            tmo_q <= tmo_d;
            acc_q <= acc_d;
            pwr_q <= pwr_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (rts_q)
            RTS_NEGATED:  rts_n = 1'b1;
            RTS_ASSERTED: rts_n = 1'b0;
        endcase
        unique case (tmo_q)
            TMO_OFF: tmo_mode = 1'b0;
            TMO_ON:  tmo_mode = 1'b1;
        endcase
        unique case (acc_q)
            ACC_AT_READ:  accum_mode = 1'b0;
            ACC_AT_ENTRY: accum_mode = 1'b1;
        endcase
        unique case (pwr_q)
            PWR_RUN:  pwr_down = 1'b0;
            PWR_DOWN: pwr_down = 1'b1;
        endcase
    end

    p_rts_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rts_on |=> !rts_n);

    p_rts_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rts_off |=> rts_n);

    p_tmo_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_on |=> tmo_mode);

    p_tmo_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_off |=> !tmo_mode);

    p_accum_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accum_mode |=> accum_mode);

    p_pwr_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_enter |=> pwr_down);

    p_pwr_leave_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_leave |=> !pwr_down);

    p_levels_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(rts_n) && $stable(tmo_mode) &&
                    $stable(accum_mode) && $stable(pwr_down)));

endmodule

// File: rtl/uart_cmd_decoder.sv
module uart_cmd_decoder
    import uart_cmd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_en,
    output logic              rx_en,
    output logic              rx_reset,
    output logic              tx_reset,
    output logic              err_clear,
    output logic              brk_chg_clear,
    output logic              brk_start,
    output logic              brk_stop,
    output logic              mrptr_reset,
    output logic              xon_req,
    output logic              xoff_req,
    output logic              tx_resume,
    output logic              ct_start,
    output logic              ct_stop,
    output logic              rts_n,
    output logic              tmo_mode,
    output logic              accum_mode,
    output logic              pwr_down
);

    localparam int LOCK_POS = DATA_W - 1;
    localparam int TXEN_POS = DATA_W - 2;
    localparam int RXEN_POS = DATA_W - 3;

    logic [CMD_W-1:0]      code;
    logic [NUM_PULSES-1:0] pulse;

    assign code = wr_data[CMD_W-1:0];

    cmd_enable_ctl u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .lock_bit (wr_data[LOCK_POS]),
        .tx_bit   (wr_data[TXEN_POS]),
        .rx_bit   (wr_data[RXEN_POS]),
        .tx_en    (tx_en),
        .rx_en    (rx_en)
    );

    cmd_pulse_gen #(.N_PULSE(NUM_PULSES)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .code  (code),
        .pulse (pulse)
    );

    cmd_mode_ctl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .code       (code),
        .rts_n      (rts_n),
        .tmo_mode   (tmo_mode),
        .accum_mode (accum_mode),
        .pwr_down   (pwr_down)
    );

    assign rx_reset      = pulse[P_RX_RST];
    assign tx_reset      = pulse[P_TX_RST];
    assign err_clear     = pulse[P_ERR_CLR];
    assign brk_chg_clear = pulse[P_BRKCHG_CLR];
    assign brk_start     = pulse[P_BRK_START];
    assign brk_stop      = pulse[P_BRK_STOP];
    assign mrptr_reset   = pulse[P_MRP_RST];
    assign xon_req       = pulse[P_XON];
    assign xoff_req      = pulse[P_XOFF];
    assign tx_resume     = pulse[P_TX_RESUME];
    assign ct_start      = pulse[P_CT_START];
    assign ct_stop       = pulse[P_CT_STOP];

    always @(posedge clk) begin
        if (!rst_n) begin
            a_reset_quiet_r10: assert (!tx_en && !rx_en && rts_n && !tmo_mode &&
                                       !accum_mode && !pwr_down && pulse == '0);
        end
    end

    p_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_reset && !$past(wr_en)) |-> 1'b0);

endmodule

// File: tb/tb_uart_cmd_decoder.sv
module tb_uart_cmd_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;

    logic tx_en, rx_en, rx_reset, tx_reset, err_clear, brk_chg_clear;
    logic brk_start, brk_stop, mrptr_reset, xon_req, xoff_req, tx_resume;
    logic ct_start, ct_stop, rts_n, tmo_mode, accum_mode, pwr_down;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic m_tx, m_rx, m_rts_n, m_tmo, m_acc, m_pwr;

    always #2 clk = ~clk;

    uart_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tx_en(tx_en), .rx_en(rx_en), .rx_reset(rx_reset), .tx_reset(tx_reset),
        .err_clear(err_clear), .brk_chg_clear(brk_chg_clear),
        .brk_start(brk_start), .brk_stop(brk_stop), .mrptr_reset(mrptr_reset),
        .xon_req(xon_req), .xoff_req(xoff_req), .tx_resume(tx_resume),
        .ct_start(ct_start), .ct_stop(ct_stop), .rts_n(rts_n),
        .tmo_mode(tmo_mode), .accum_mode(accum_mode), .pwr_down(pwr_down)
    );

    function automatic logic [11:0] obs_pulses();
        return {ct_stop, ct_start, tx_resume, xoff_req, xon_req, mrptr_reset,
                brk_stop, brk_start, brk_chg_clear, err_clear, tx_reset, rx_reset};
    endfunction

    function automatic logic [3:0] obs_levels();
        return {rts_n, tmo_mode, accum_mode, pwr_down};
    endfunction

    // Expected pulse vector from the code list in R3
    function automatic logic [11:0] exp_pulses(input logic [4:0] c);
        logic [11:0] v = '0;
        case (c)
            5'd2:  v[0]  = 1'b1;
            5'd3:  v[1]  = 1'b1;
            5'd4:  v[2]  = 1'b1;
            5'd5:  v[3]  = 1'b1;
            5'd6:  v[4]  = 1'b1;
            5'd7:  v[5]  = 1'b1;
            5'd11: v[6]  = 1'b1;
            5'd16: v[7]  = 1'b1;
            5'd17: v[8]  = 1'b1;
            5'd22: v[9]  = 1'b1;
            5'd18: v[10] = 1'b1;
            5'd19: v[11] = 1'b1;
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        logic [4:0]  c;
        logic [11:0] ep;
        string       ptag;
        c = d[4:0];
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        // model update from requirements
        if (d[7]) begin
            m_tx = d[6];
            m_rx = d[5];
        end
        case (c)
            5'd8:  m_rts_n = 1'b0;
            5'd9:  m_rts_n = 1'b1;
            5'd10: m_tmo   = 1'b1;
            5'd12: m_tmo   = 1'b0;
            5'd13: m_acc   = 1'b1;
            5'd14: m_pwr   = 1'b1;
            5'd15: m_pwr   = 1'b0;
            default: ;
        endcase
        ep = exp_pulses(c);
        ptag = (ep == '0) ? "R4 pulse" : "R3 pulse";
        check(obs_pulses() == ep, ptag, {4'h0, obs_pulses()}, {4'h0, ep});
        if (d[7])
            check({tx_en, rx_en} == {m_tx, m_rx}, "R2 enable load",
                  {14'h0, tx_en, rx_en}, {14'h0, m_tx, m_rx});
        else
            check({tx_en, rx_en} == {m_tx, m_rx}, "R1 enable hold",
                  {14'h0, tx_en, rx_en}, {14'h0, m_tx, m_rx});
        check(obs_levels() == {m_rts_n, m_tmo, m_acc, m_pwr},
              "R6 R7 R8 R9 levels (R4 when reserved)",
              {12'h0, obs_levels()}, {12'h0, m_rts_n, m_tmo, m_acc, m_pwr});
        // one cycle later, no strobe: pulse gone, levels held
        @(negedge clk);
        check(obs_pulses() == '0, "R5 pulse falls", {4'h0, obs_pulses()}, 16'h0);
        check({obs_levels(), tx_en, rx_en} == {m_rts_n, m_tmo, m_acc, m_pwr, m_tx, m_rx},
              "R11 hold after write", {10'h0, obs_levels(), tx_en, rx_en},
              {10'h0, m_rts_n, m_tmo, m_acc, m_pwr, m_tx, m_rx});
    endtask

    task automatic model_reset();
        m_tx = 1'b0; m_rx = 1'b0; m_rts_n = 1'b1;
        m_tmo = 1'b0; m_acc = 1'b0; m_pwr = 1'b0;
    endtask

    task automatic check_reset_state(input string tag);
        check({tx_en, rx_en, rts_n, tmo_mode, accum_mode, pwr_down} == 6'b001000 &&
              obs_pulses() == '0, tag,
              {4'h0, tx_en, rx_en, rts_n, tmo_mode, accum_mode, pwr_down, 6'h0},
              {4'h0, 6'b001000, 6'h0});
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check_reset_state("R10 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("R10 after release");

        // idle cycles with data toggling but no strobe
        for (int k = 0; k < 8; k++) begin
            wr_data = 8'hE0 | 8'(k + 8);
            @(negedge clk);
            check(obs_pulses() == '0 && {tx_en, rx_en} == 2'b00 &&
                  obs_levels() == 4'b1000, "R11 idle no strobe",
                  {10'h0, obs_levels(), tx_en, rx_en}, 16'h0020);
        end

        for (int d = 0; d < 256; d++) do_write(8'(d));
        for (int d = 255; d >= 0; d--) do_write(8'(d));

        // targeted: locked command with enable bits set, after enables cleared
        do_write(8'h80);
        do_write(8'h68);
        do_write(8'hE9);
        do_write(8'h0E);
        do_write(8'h0A);

        // reset mid-run clears all levels
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        check_reset_state("R10 mid-run reset");
        rst_n = 1'b1;
        do_write(8'hD2);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule